// File: doc/BRIEF.md
# Timer Compare Output Unit

This unit holds a 16-bit compare value and watches one of two free-running 16-bit up-counters, also held inside the unit. The time base is picked by a select bit. When the selected count first becomes equal to the compare value, the unit acts on an output pin latch according to a 4-bit mode code. The action can drive the pin high, drive it low or toggle it. Every such match also raises a sticky interrupt flag, which stays set until it is cleared by a pulse on the clear input.

One mode turns the match into a trigger event. It restarts the selected counter from zero and gives a one-cycle converter-start strobe. The compare value then sets the counter's period. Software reaches the unit through two write strobes: one loads the compare value, and the other loads the mode code and the timer select. Each counter has its own run input, so a counter can be held at a value to test stalled-match behaviour.

Top module: `tcmp_unit`

## Requirements
- R1: After reset the pin output, the interrupt flag, both counts, both timer-reset strobes and the converter strobe are all 0.
- R2: Each counter adds one on every cycle its run input is high, wrapping from 16'hFFFF to 0. It holds its value while its run input is low, unless the unit clears it.
- R3: A timer select of 0 compares against counter 0, and a select of 1 compares against counter 1. A count of the other counter equal to the compare value has no effect.
- R4: With mode 4'b1000 a match drives the pin high, and with mode 4'b1001 a match drives it low. The pin changes on the clock edge that ends the match cycle.
- R5: With mode 4'b0010 each match inverts the pin.
- R6: A match is taken only on the first cycle that the selected count equals the compare value. A counter stalled at that value produces no further action.
- R7: With mode 4'b1010 a match sets the interrupt flag and leaves the pin unchanged.
- R8: With mode 4'b1011 a match sets the flag and leaves the pin unchanged. In the next cycle the converter strobe and the reset strobe of the selected counter (bit 0 for counter 0, bit 1 for counter 1) are high for exactly one cycle, and in that same cycle the selected counter reads 0. The period is therefore compare value + 1 cycles, and the other counter is not disturbed.
- R9: The interrupt flag is set by a match in any of the five active modes and stays set until flag_clr is high. A match and a clear in the same cycle leave it set.
- R10: Writing mode 4'b0000 forces the pin low on the next edge. A match under any code other than 0010, 1000, 1001, 1010 or 1011 changes neither the pin nor the flag.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_we | input | 1 | Load mode code and timer select |
| cfg_mode | input | 4 | Mode code to load |
| cfg_tsel | input | SELW (1) | Timer select to load |
| cmp_we | input | 1 | Load compare value |
| cmp_val | input | TW (16) | Compare value to load |
| tmr_run | input | NUM_TMR (2) | Per-counter run enable |
| flag_clr | input | 1 | Clear pulse for the interrupt flag |
| tmr_cnt | output | NUM_TMR x TW (2x16) | Current counter values |
| tmr_rst | output | NUM_TMR (2) | Per-counter reset strobe from a trigger match |
| adc_start | output | 1 | Converter-start strobe |
| pin_out | output | 1 | Compare output pin latch |
| irq_flag | output | 1 | Sticky interrupt flag |

## Verification
The hardest situation to reach is a match that coincides with another event: a flag clear in the same cycle, or a counter frozen on the compare value. Free-running counters would reach these cycles only by chance. The bench holds the run inputs low while it reloads compare values, then releases the counter a known number of cycles before the match. It raises the clear or freezes the counter in exactly the match cycle. For the trigger mode, it follows two full periods, so that both the strobe alignment and the compare + 1 period are checked.

// File: rtl/tcmp_pkg.sv
package tcmp_pkg;

    typedef logic [3:0] mode_t;

    localparam mode_t MODE_OFF    = 4'b0000;
    localparam mode_t MODE_TOGGLE = 4'b0010;
    localparam mode_t MODE_SET    = 4'b1000;
    localparam mode_t MODE_CLR    = 4'b1001;
    localparam mode_t MODE_SWINT  = 4'b1010;
    localparam mode_t MODE_TRIG   = 4'b1011;

    typedef enum logic [1:0] {
        PIN_KEEP,
        PIN_HIGH,
        PIN_LOW,
        PIN_FLIP
    } pin_op_e;

    typedef struct packed {
        logic    active;
        pin_op_e pin_op;
        logic    trigger;
    } mode_dec_t;

    function automatic mode_dec_t decode_mode(input mode_t m);
        mode_dec_t d;
        d.active  = 1'b1;
        d.pin_op  = PIN_KEEP;
        d.trigger = 1'b0;
        case (m)
            MODE_TOGGLE: d.pin_op = PIN_FLIP;
            MODE_SET:    d.pin_op = PIN_HIGH;
            MODE_CLR:    d.pin_op = PIN_LOW;
            MODE_SWINT:  d.pin_op = PIN_KEEP;
            MODE_TRIG:   d.trigger = 1'b1;
            default:     d.active = 1'b0;
        endcase
        return d;
    endfunction

endpackage

// File: rtl/tcmp_timer.sv
module tcmp_timer #(
    parameter int TW = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          run_i,
    input  logic          clear_i,
    output logic [TW-1:0] cnt_o
);

    logic [TW-1:0] cnt_d, cnt_q;

    always_comb begin
        cnt_d = cnt_q;
        if (clear_i) begin
            cnt_d = '0;
        end else if (run_i) begin
            cnt_d = cnt_q + TW'(1);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_d;
        end
    end

    assign cnt_o = cnt_q;

endmodule

// File: rtl/tcmp_match.sv
module tcmp_match #(
    parameter int TW      = 16,
    parameter int NUM_TMR = 2,
    parameter int SELW    = 1
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic [NUM_TMR-1:0][TW-1:0]  cnt_i,
    input  logic [SELW-1:0]             sel_i,
    input  logic [TW-1:0]               cmp_i,
    output logic                        hit_o
);

    logic [TW-1:0] base;
    logic          eq;
    logic          eq_d, eq_q;

    // Pick the selected time base; an out-of-range select reads as zero.
    always_comb begin
        base = '0;
        for (int i = 0; i < NUM_TMR; i++) begin
            if (sel_i == SELW'(i)) begin
                base = cnt_i[i];
            end
        end
    end

    assign eq = (base == cmp_i);

    always_comb begin
        eq_d = eq;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            eq_q <= 1'b0;
        end else begin
            eq_q <= eq_d;
        end
    end

    // Only the first cycle of equality counts as a match.
    assign hit_o = eq && !eq_q;

endmodule

// File: rtl/tcmp_action.sv
module tcmp_action
    import tcmp_pkg::*;
(
    input  logic  clk,
    input  logic  rst_n,
    input  mode_t mode_i,
    input  logic  hit_i,
    input  logic  force_low_i,
    input  logic  flag_clr_i,
    output logic  pin_o,
    output logic  flag_o,
    output logic  trig_o,
    output logic  trig_now_o
);

    typedef struct packed {
        logic pin;
        logic flag;
        logic trig;
    } act_state_t;

    act_state_t st_d, st_q;
    mode_dec_t  dec;
    logic       fire;

    always_comb begin
        dec  = decode_mode(mode_i);
        fire = hit_i && dec.active;
        st_d = st_q;
        st_d.trig = 1'b0;

        if (flag_clr_i) begin
            st_d.flag = 1'b0;
        end

        if (fire) begin
            st_d.flag = 1'b1;
            st_d.trig = dec.trigger;
            case (dec.pin_op)
                PIN_HIGH: st_d.pin = 1'b1;
                PIN_LOW:  st_d.pin = 1'b0;
                PIN_FLIP: st_d.pin = ~st_q.pin;
                default:  st_d.pin = st_q.pin;
            endcase
        end

        if (force_low_i) begin
            st_d.pin = 1'b0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign pin_o      = st_q.pin;
    assign flag_o     = st_q.flag;
    assign trig_o     = st_q.trig;
    assign trig_now_o = fire && dec.trigger;

endmodule

// File: rtl/tcmp_unit.sv
module tcmp_unit
    import tcmp_pkg::*;
#(
    parameter int TW      = 16,
    parameter int NUM_TMR = 2,
    parameter int SELW    = (NUM_TMR > 1) ? $clog2(NUM_TMR) : 1
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       cfg_we,
    input  logic [3:0]                 cfg_mode,
    input  logic [SELW-1:0]            cfg_tsel,
    input  logic                       cmp_we,
    input  logic [TW-1:0]              cmp_val,
    input  logic [NUM_TMR-1:0]         tmr_run,
    input  logic                       flag_clr,
    output logic [NUM_TMR-1:0][TW-1:0] tmr_cnt,
    output logic [NUM_TMR-1:0]         tmr_rst,
    output logic                       adc_start,
    output logic                       pin_out,
    output logic                       irq_flag
);

    typedef struct packed {
        mode_t              mode;
        logic [SELW-1:0]    tsel;
        logic [TW-1:0]      cmp;
        logic [NUM_TMR-1:0] rst;
    } cfg_state_t;

    cfg_state_t         cfg_d, cfg_q;
    logic               hit;
    logic               trig_now;
    logic               trig_q;
    logic               force_low;
    logic [NUM_TMR-1:0] tmr_clear;

    assign force_low = cfg_we && (cfg_mode == MODE_OFF);

    always_comb begin
        cfg_d = cfg_q;
        if (cfg_we) begin
            cfg_d.mode = cfg_mode;
            cfg_d.tsel = cfg_tsel;
        end
        if (cmp_we) begin
            cfg_d.cmp = cmp_val;
        end
        cfg_d.rst = tmr_clear;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cfg_q <= '0;
        end else begin
            cfg_q <= cfg_d;
        end
    end

    generate
        for (genvar i = 0; i < NUM_TMR; i++) begin : g_tmr
            assign tmr_clear[i] = trig_now && (cfg_q.tsel == SELW'(i));

            tcmp_timer #(.TW(TW)) u_timer (
                .clk     (clk),
                .rst_n   (rst_n),
                .run_i   (tmr_run[i]),
                .clear_i (tmr_clear[i]),
                .cnt_o   (tmr_cnt[i])
            );
        end
    endgenerate

    tcmp_match #(.TW(TW), .NUM_TMR(NUM_TMR), .SELW(SELW)) u_match (
        .clk   (clk),
        .rst_n (rst_n),
        .cnt_i (tmr_cnt),
        .sel_i (cfg_q.tsel),
        .cmp_i (cfg_q.cmp),
        .hit_o (hit)
    );

    tcmp_action u_action (
        .clk         (clk),
        .rst_n       (rst_n),
        .mode_i      (cfg_q.mode),
        .hit_i       (hit),
        .force_low_i (force_low),
        .flag_clr_i  (flag_clr),
        .pin_o       (pin_out),
        .flag_o      (irq_flag),
        .trig_o      (trig_q),
        .trig_now_o  (trig_now)
    );

    assign tmr_rst   = cfg_q.rst;
    assign adc_start = trig_q;

endmodule

module tcmp_unit_chk #(
    parameter int TW      = 16,
    parameter int NUM_TMR = 2
) (
    input logic                       clk,
    input logic                       rst_n,
    input logic                       cfg_we,
    input logic [3:0]                 cfg_mode,
    input logic                       flag_clr,
    input logic [NUM_TMR-1:0]         tmr_run,
    input logic [NUM_TMR-1:0][TW-1:0] tmr_cnt,
    input logic [NUM_TMR-1:0]         tmr_rst,
    input logic                       adc_start,
    input logic                       pin_out,
    input logic                       irq_flag,
    input logic [3:0]                 mode_q
);

    p_strobe_single_r8: assert property (@(posedge clk) disable iff (!rst_n)
        adc_start |=> !adc_start);

    p_strobe_onehot_r8: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(tmr_rst));

    p_strobe_align_r8: assert property (@(posedge clk) disable iff (!rst_n)
        adc_start |-> ($countones(tmr_rst) == 1));

    p_flag_sticky_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_flag && !flag_clr) |=> irq_flag);

    p_swint_pin_r7: assert property (@(posedge clk) disable iff (!rst_n)
        ((mode_q == 4'b1010) && !cfg_we) |=> $stable(pin_out));

    p_off_low_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_we && (cfg_mode == 4'b0000)) |=> !pin_out);

    generate
        for (genvar i = 0; i < NUM_TMR; i++) begin : g_chk
            p_zero_after_trig_r8: assert property (@(posedge clk) disable iff (!rst_n)
                tmr_rst[i] |-> (tmr_cnt[i] == '0));

            p_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
                !tmr_run[i] |=> (tmr_rst[i] || (tmr_cnt[i] == $past(tmr_cnt[i]))));

            p_step_r2: assert property (@(posedge clk) disable iff (!rst_n)
                tmr_run[i] |=> (tmr_rst[i] || (tmr_cnt[i] == $past(tmr_cnt[i]) + TW'(1))));
        end
    endgenerate

endmodule

bind tcmp_unit tcmp_unit_chk #(.TW(TW), .NUM_TMR(NUM_TMR)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .cfg_we    (cfg_we),
    .cfg_mode  (cfg_mode),
    .flag_clr  (flag_clr),
    .tmr_run   (tmr_run),
    .tmr_cnt   (tmr_cnt),
    .tmr_rst   (tmr_rst),
    .adc_start (adc_start),
    .pin_out   (pin_out),
    .irq_flag  (irq_flag),
    .mode_q    (cfg_q.mode)
);

// File: tb/tcmp_unit_test.sv
module tcmp_unit_test;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             cfg_we = 1'b0;
    logic [3:0]       cfg_mode = 4'b0;
    logic [0:0]       cfg_tsel = 1'b0;
    logic             cmp_we = 1'b0;
    logic [15:0]      cmp_val = 16'h0;
    logic [1:0]       tmr_run = 2'b0;
    logic             flag_clr = 1'b0;
    logic [1:0][15:0] tmr_cnt;
    logic [1:0]       tmr_rst;
    logic             adc_start;
    logic             pin_out;
    logic             irq_flag;

    int n_chk = 0;
    int n_err = 0;

    always #4 clk = ~clk;

    tcmp_unit uut (
        .clk       (clk),
        .rst_n     (rst_n),
        .cfg_we    (cfg_we),
        .cfg_mode  (cfg_mode),
        .cfg_tsel  (cfg_tsel),
        .cmp_we    (cmp_we),
        .cmp_val   (cmp_val),
        .tmr_run   (tmr_run),
        .flag_clr  (flag_clr),
        .tmr_cnt   (tmr_cnt),
        .tmr_rst   (tmr_rst),
        .adc_start (adc_start),
        .pin_out   (pin_out),
        .irq_flag  (irq_flag)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic step(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic do_reset();
        rst_n = 1'b0;
        cfg_we = 1'b0; cmp_we = 1'b0; tmr_run = 2'b00; flag_clr = 1'b0;
        step(2);
        rst_n = 1'b1;
        step(1);
    endtask

    task automatic set_cfg(input logic [3:0] m, input logic t);
        cfg_we = 1'b1; cfg_mode = m; cfg_tsel = t;
        step(1);
        cfg_we = 1'b0;
    endtask

    task automatic set_cmp(input logic [15:0] v);
        cmp_we = 1'b1; cmp_val = v;
        step(1);
        cmp_we = 1'b0;
    endtask

    task automatic pulse_clr();
        flag_clr = 1'b1;
        step(1);
        flag_clr = 1'b0;
    endtask

    task automatic t_reset_r1();
        do_reset();
        chk("R1 pin", pin_out, 0);
        chk("R1 flag", irq_flag, 0);
        chk("R1 cnt0", tmr_cnt[0], 0);
        chk("R1 cnt1", tmr_cnt[1], 0);
        chk("R1 tmr_rst", tmr_rst, 0);
        chk("R1 adc", adc_start, 0);
    endtask

    task automatic t_count_r2();
        do_reset();
        tmr_run = 2'b01;
        step(5);
        chk("R2 cnt0 counts", tmr_cnt[0], 5);
        chk("R2 cnt1 idle", tmr_cnt[1], 0);
        tmr_run = 2'b00;
        step(3);
        chk("R2 cnt0 holds", tmr_cnt[0], 5);
        tmr_run = 2'b10;
        step(65536);
        chk("R2 cnt1 wraps", tmr_cnt[1], 0);
        tmr_run = 2'b00;
    endtask

    task automatic t_select_r3();
        do_reset();
        set_cmp(16'd4);
        set_cfg(4'b1000, 1'b1);
        tmr_run = 2'b10;
        step(4);
        chk("R3 cnt1 at cmp", tmr_cnt[1], 4);
        step(1);
        chk("R3 sel1 pin high", pin_out, 1);
        do_reset();
        set_cmp(16'd3);
        set_cfg(4'b1000, 1'b1);
        tmr_run = 2'b01;
        step(5);
        chk("R3 cnt0 passed cmp", tmr_cnt[0], 5);
        chk("R3 unselected pin", pin_out, 0);
        chk("R3 unselected flag", irq_flag, 0);
        tmr_run = 2'b00;
    endtask

    task automatic t_set_clr_r4();
        do_reset();
        set_cmp(16'd3);
        set_cfg(4'b1000, 1'b0);
        tmr_run = 2'b01;
        step(3);
        chk("R4 match cycle cnt", tmr_cnt[0], 3);
        chk("R4 pin before edge", pin_out, 0);
        step(1);
        chk("R4 set pin", pin_out, 1);
        chk("R9 flag on set", irq_flag, 1);
        tmr_run = 2'b00;
        set_cmp(16'd7);
        set_cfg(4'b1001, 1'b0);
        pulse_clr();
        chk("R9 flag cleared", irq_flag, 0);
        tmr_run = 2'b01;
        step(3);
        chk("R4 pin before low", pin_out, 1);
        step(1);
        chk("R4 clear pin", pin_out, 0);
        tmr_run = 2'b00;
    endtask

    task automatic t_toggle_r5_r6();
        do_reset();
        set_cmp(16'd2);
        set_cfg(4'b0010, 1'b0);
        tmr_run = 2'b01;
        step(2);
        tmr_run = 2'b00;
        chk("R6 stalled cnt", tmr_cnt[0], 2);
        step(1);
        chk("R5 first toggle", pin_out, 1);
        step(3);
        chk("R6 no re-toggle", pin_out, 1);
        set_cmp(16'd5);
        tmr_run = 2'b01;
        step(3);
        chk("R5 cnt at new cmp", tmr_cnt[0], 5);
        step(1);
        chk("R5 second toggle", pin_out, 0);
        tmr_run = 2'b00;
    endtask

    task automatic t_swint_r7();
        do_reset();
        set_cmp(16'd2);
        set_cfg(4'b1010, 1'b0);
        tmr_run = 2'b01;
        step(3);
        chk("R7 flag", irq_flag, 1);
        chk("R7 pin kept", pin_out, 0);
        tmr_run = 2'b00;
    endtask

    task automatic t_trigger_r8();
        do_reset();
        set_cmp(16'd3);
        set_cfg(4'b1011, 1'b0);
        tmr_run = 2'b11;
        step(3);
        chk("R8 cnt0 at cmp", tmr_cnt[0], 3);
        chk("R8 no strobe yet", tmr_rst, 0);
        step(1);
        chk("R8 tmr_rst bit0", tmr_rst, 2'b01);
        chk("R8 adc strobe", adc_start, 1);
        chk("R8 cnt0 zero", tmr_cnt[0], 0);
        chk("R8 cnt1 undisturbed", tmr_cnt[1], 4);
        step(1);
        chk("R8 strobe one cycle", tmr_rst, 0);
        chk("R8 adc one cycle", adc_start, 0);
        chk("R8 cnt0 restarts", tmr_cnt[0], 1);
        step(2);
        chk("R8 adc quiet", adc_start, 0);
        step(1);
        chk("R8 period cmp+1", adc_start, 1);
        chk("R8 flag", irq_flag, 1);
        chk("R8 pin kept", pin_out, 0);
        do_reset();
        set_cmp(16'd2);
        set_cfg(4'b1011, 1'b1);
        tmr_run = 2'b11;
        step(3);
        chk("R8 tmr_rst bit1", tmr_rst, 2'b10);
        chk("R8 cnt1 zero", tmr_cnt[1], 0);
        chk("R8 cnt0 undisturbed", tmr_cnt[0], 3);
        tmr_run = 2'b00;
    endtask

    task automatic t_flag_r9();
        do_reset();
        set_cmp(16'd1);
        set_cfg(4'b1010, 1'b0);
        tmr_run = 2'b01;
        step(2);
        chk("R9 flag set", irq_flag, 1);
        tmr_run = 2'b00;
        set_cmp(16'd4);
        tmr_run = 2'b01;
        step(2);
        flag_clr = 1'b1;
        step(1);
        flag_clr = 1'b0;
        chk("R9 set wins over clear", irq_flag, 1);
        pulse_clr();
        chk("R9 clear", irq_flag, 0);
        tmr_run = 2'b00;
    endtask

    task automatic t_off_r10();
        do_reset();
        set_cmp(16'd2);
        set_cfg(4'b1000, 1'b0);
        tmr_run = 2'b01;
        step(3);
        tmr_run = 2'b00;
        chk("R10 pin high first", pin_out, 1);
        set_cfg(4'b0000, 1'b0);
        chk("R10 forced low", pin_out, 0);
        pulse_clr();
        set_cmp(16'd6);
        set_cfg(4'b0101, 1'b0);
        tmr_run = 2'b01;
        step(4);
        chk("R10 cnt passed cmp", tmr_cnt[0], 7);
        chk("R10 inactive pin", pin_out, 0);
        chk("R10 inactive flag", irq_flag, 0);
        tmr_run = 2'b00;
    endtask

    initial begin
        step(1);
        t_reset_r1();
        t_count_r2();
        t_select_r3();
        t_set_clr_r4();
        t_toggle_r5_r6();
        t_swint_r7();
        t_trigger_r8();
        t_flag_r9();
        t_off_r10();
        $display("CHECKS %0d ERRORS %0d", n_chk, n_err);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        n_err++;
        $display("FAIL watchdog actual timeout expected completion");
        $display("CHECKS %0d ERRORS %0d", n_chk, n_err);
        $finish;
    end

endmodule